// File: doc/BRIEF.md
# Peripheral Security Attribute Controller

This block holds one security attribute bit for each of up to 32 on-chip peripherals and drives the whole set as a 32-bit vector to the peripherals. An attribute of 1 marks a peripheral as non-secure and 0 marks it as secure. Software never writes the attribute word directly. It issues commands instead. One command register moves the selected bits to non-secure and another moves them to secure. Only the bits written as 1 take part in a command.

The 32 attributes form two independent 16-bit halves. Each half has three word registers: a status view, a make-non-secure command and a make-secure command. The bus is a plain single-cycle register port with a word address, write and read enables, and a qualifier that marks each access as secure or not. Only secure accesses may change attributes. Anyone may read the status. Attribute positions that no peripheral uses are tied to zero.

Top module: `perSecAttr`

## Requirements
- R1: After reset every attribute bit is 0, so `attrVec` is 0 and both status reads return 0.
- R2: A secure write to word 1 sets to 1 each bit of attributes 15:0 whose write-data bit (in bits 15:0) is 1, and leaves bits written as 0 unchanged.
- R3: A secure write to word 2 clears to 0 each bit of attributes 15:0 whose write-data bit is 1, and leaves bits written as 0 unchanged.
- R4: Words 3, 4 and 5 act on attributes 31:16 in the same way as words 0, 1 and 2 act on attributes 15:0 (status, set-non-secure, set-secure). Write-data bit k maps to attribute 16+k.
- R5: Reading any of the command words (1, 2, 4, 5) returns 0.
- R6: A status read (word 0 or 3) returns the half's 16 attributes in bits 15:0 and zeros in bits 31:16. Bits 31:16 of write data have no effect.
- R7: Only attribute positions 0 to 9 and 16 to 24 are implemented. All other positions read as 0 in status and `attrVec`, and command writes to them have no effect.
- R8: A write with `accSecure` low changes no attribute. Status reads return the attributes whatever the value of `accSecure`.
- R9: Reads of words 6 to 15 return 0, and writes to those words change nothing.
- R10: An attribute change made by a write at one clock edge shows on `attrVec` and in status reads in the cycle that follows, and `attrVec` always equals the two status halves.
- R11: `regRdData` is 0 whenever `regRdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Word address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data; only bits 15:0 are used |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 32 | Read data, combinational from the address |
| accSecure | input | 1 | High when the access comes from a secure master |
| attrVec | output | 32 | Attribute bits, 1 = non-secure |

## Verification
The bench drives every word address from 0 to 15 with a set of data patterns under both values of the security qualifier. After each write it reads back all six words and `attrVec` and compares them with a model computed in the bench. The patterns include all-ones, single ends of the half, alternating bits and words with junk in the upper 16 bits. Together they separate set from clear, lower from upper half, implemented from unused positions and meaningful from ignored data bits. The secure/non-secure pairs separate accepted writes from dropped ones. The writes to words 6 to 15 show whether the decode is complete.

// File: rtl/perSecAttrPkg.sv
package perSecAttrPkg;
  localparam int NUM_HALVES    = 2;
  localparam int HALF_W        = 16;
  localparam int REGS_PER_HALF = 3;
  localparam int WORD_W        = 32;
  localparam int ATTR_W        = NUM_HALVES * HALF_W;
  localparam int NUM_REGS      = NUM_HALVES * REGS_PER_HALF;
  localparam int HALF_IDX_W    = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1;

  // register slot within a half; the order is fixed by the map
  typedef enum logic [1:0] {
    SLOT_STATUS = 2'd0,
    SLOT_SET_NS = 2'd1,
    SLOT_SET_SC = 2'd2
  } regSlot_e;

  typedef struct packed {
    logic [NUM_HALVES-1:0] setNs;
    logic [NUM_HALVES-1:0] setSec;
    logic                  rdStatus;
    logic [HALF_IDX_W-1:0] rdHalf;
  } ctrlStrobe_t;
endpackage

// File: rtl/perSecAttrCtrl.sv
module perSecAttrCtrl
  import perSecAttrPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              accSecure,
  output ctrlStrobe_t       strb
);
  logic wrOk;
  assign wrOk = wrEn & accSecure;

  always_comb begin
    strb = '0;
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (int'(addr) == h * REGS_PER_HALF + int'(SLOT_STATUS) && rdEn) begin
        strb.rdStatus = 1'b1;
        strb.rdHalf   = HALF_IDX_W'(h);
      end
      if (int'(addr) == h * REGS_PER_HALF + int'(SLOT_SET_NS) && wrOk)
        strb.setNs[h] = 1'b1;
      if (int'(addr) == h * REGS_PER_HALF + int'(SLOT_SET_SC) && wrOk)
        strb.setSec[h] = 1'b1;
    end
  end
endmodule

// File: rtl/perSecAttrData.sv
module perSecAttrData
  import perSecAttrPkg::*;
#(
  parameter logic [ATTR_W-1:0] IMPL_MASK = 32'h01FF_03FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [HALF_W-1:0] cmdBits,
  output logic [WORD_W-1:0] rdData,
  output logic [ATTR_W-1:0] attr
);
  logic [NUM_HALVES-1:0][HALF_W-1:0] halfQ;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : gHalf
    localparam logic [HALF_W-1:0] H_MASK = IMPL_MASK[h*HALF_W +: HALF_W];
    logic [HALF_W-1:0] halfD;

    always_comb begin
      halfD = halfQ[h];
      if (strb.setNs[h])  halfD = halfD | cmdBits;
      if (strb.setSec[h]) halfD = halfD & ~cmdBits;
      halfD = halfD & H_MASK;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) halfQ[h] <= '0;
      else       halfQ[h] <= halfD;
    end

    assign attr[h*HALF_W +: HALF_W] = halfQ[h];
  end

  always_comb begin
    rdData = '0;
    if (strb.rdStatus)
      rdData[HALF_W-1:0] = halfQ[strb.rdHalf];
  end
endmodule

// File: rtl/perSecAttr.sv
module perSecAttr
  import perSecAttrPkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ATTR_W-1:0] IMPL_MASK = 32'h01FF_03FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [WORD_W-1:0] regRdData,
  input  logic              accSecure,
  output logic [ATTR_W-1:0] attrVec
);
  ctrlStrobe_t strb;
  logic        unusedWrHi;

  assign unusedWrHi = ^regWrData[WORD_W-1:HALF_W];

  perSecAttrCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .addr      (regAddr),
    .wrEn      (regWrEn),
    .rdEn      (regRdEn),
    .accSecure (accSecure),
    .strb      (strb)
  );

  perSecAttrData #(.IMPL_MASK(IMPL_MASK)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cmdBits (regWrData[HALF_W-1:0]),
    .rdData  (regRdData),
    .attr    (attrVec)
  );
endmodule

// File: rtl/perSecAttrChk.sv
module perSecAttrChk
  import perSecAttrPkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ATTR_W-1:0] IMPL_MASK = 32'h01FF_03FF
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [WORD_W-1:0] regWrData,
  input logic              regRdEn,
  input logic [WORD_W-1:0] regRdData,
  input logic              accSecure,
  input logic [ATTR_W-1:0] attrVec
);
  logic [HALF_W-1:0] loMaskedCmd;
  assign loMaskedCmd = regWrData[HALF_W-1:0] & IMPL_MASK[HALF_W-1:0];

  p_set_ns_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && accSecure && int'(regAddr) == 1)
      |=> ((attrVec[HALF_W-1:0] & $past(loMaskedCmd)) == $past(loMaskedCmd)));

  p_set_sec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && accSecure && int'(regAddr) == 2)
      |=> ((attrVec[HALF_W-1:0] & $past(loMaskedCmd)) == '0));

  p_cmd_read_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && (int'(regAddr) == 1 || int'(regAddr) == 2 ||
                 int'(regAddr) == 4 || int'(regAddr) == 5)) |-> regRdData == '0);

  p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (attrVec & ~IMPL_MASK) == '0);

  p_drop_nonsecure_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !accSecure) |=> $stable(attrVec));

  p_range_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && int'(regAddr) >= NUM_REGS) |-> regRdData == '0);

  p_range_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && int'(regAddr) >= NUM_REGS) |=> $stable(attrVec));

  p_status_match_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && int'(regAddr) == 3)
      |-> regRdData == {{(WORD_W-HALF_W){1'b0}}, attrVec[ATTR_W-1:HALF_W]});

  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |-> regRdData == '0);
endmodule

bind perSecAttr perSecAttrChk #(.ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdEn   (regRdEn),
  .regRdData (regRdData),
  .accSecure (accSecure),
  .attrVec   (attrVec)
);

// File: tb/perSecAttr_test.sv
`timescale 1ns/1ps
module perSecAttr_test;
  localparam logic [31:0] MASK = 32'h01FF_03FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic        accSecure = 1'b0;
  logic [31:0] attrVec;

  int nCmp = 0;
  int nBad = 0;
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  perSecAttr uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .accSecure(accSecure), .attrVec(attrVec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int i);
    case (i)
      0: return 32'h0000_FFFF;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0000_0001;
      3: return 32'h0000_8000;
      4: return 32'h0000_5555;
      5: return 32'h0000_AAAA;
      6: return 32'hFFFF_0200;
      default: return 32'h0000_03FF;
    endcase
  endfunction

  function automatic string writeTag(input int a, input bit sec);
    if (a >= 6) return "R9";
    if (!sec)   return "R8";
    case (a)
      1: return "R2";
      2: return "R3";
      4, 5: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic doWrite(input int a, input logic [31:0] d, input bit sec);
    @(negedge clk);
    regAddr = 4'(a); regWrData = d; accSecure = sec; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    if (sec && a < 6) begin
      int h = a / 3;
      int s = a % 3;
      logic [15:0] hv = model[h*16 +: 16];
      if (s == 1) hv = hv | d[15:0];
      if (s == 2) hv = hv & ~d[15:0];
      model[h*16 +: 16] = hv;
      model = model & MASK;
    end
  endtask

  task automatic readAll(input string tag);
    for (int a = 0; a < 6; a++) begin
      regAddr = 4'(a); regRdEn = 1'b1; accSecure = a[0];
      #1;
      if (a % 3 == 0)
        check({tag, " R6 R10 status"}, regRdData, {16'h0, model[(a/3)*16 +: 16]});
      else
        check("R5 command read", regRdData, 32'h0);
      @(negedge clk);
    end
    regRdEn = 1'b0;
    check({tag, " R10 attrVec"}, attrVec, model);
    check("R7 unused positions", attrVec & ~MASK, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset attrVec", attrVec, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    readAll("R1");

    for (int a = 0; a < 16; a++) begin
      for (int p = 0; p < 8; p++) begin
        for (int s = 0; s < 2; s++) begin
          doWrite(a, pattern(p), s[0]);
          readAll(writeTag(a, s[0]));
          if (a >= 6) begin
            regAddr = 4'(a); regRdEn = 1'b1; #1;
            check("R9 range read", regRdData, 32'h0);
            @(negedge clk); regRdEn = 1'b0;
          end
        end
      end
      if (a == 2 || a == 5) doWrite(a - 1, 32'hFFFF_FFFF, 1'b1);
    end

    regAddr = 4'd0; regRdEn = 1'b0; #1;
    check("R11 idle read data", regRdData, 32'h0);
    regAddr = 4'd3; #1;
    check("R11 idle read data upper", regRdData, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule